// File: doc/BRIEF.md
# Serial "x10" Pattern Detector

This block is a clocked Moore machine that watches a one-bit serial stream. It samples one bit on each rising clock edge. Its flag goes high for one clock period when the three most recent bits end in a 1 followed by a 0. That covers both target patterns, 010 and 110. Detection is continuous, so matches may overlap: in 01010 the middle 0 closes the first match and the last 0 closes the second.

The state sits in a two-bit register written like two D flip-flops, with A as the high bit and B as the low bit. Three binary codes are used. The fourth code is unused and returns to the start code on the next edge. The output is decoded from the state register alone, and the state is brought out on a port so that it can be checked.

A synchronous reset puts the machine in the start code. Bits taken in before the reset are forgotten. The start code behaves as if the bits before it were zeros. As a result, 1 followed by 0 straight after reset completes a 010 against that zero history and raises the flag.

Top module: `seqdet_top`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes 00 and `hit` is 0 after that edge. Any partly received pattern is discarded, so a 0 taken in just after reset leaves the state at 00.
- R2: A 1 sampled at any edge with `rst` low puts the state at 01 (last bit was a 1) after that edge, and `hit` is 0.
- R3: A 0 sampled while the state is 01 puts the state at 10 after that edge, and `hit` is 1 for that cycle.
- R4: The pattern 010 raises `hit` in the cycle after its final 0 is sampled.
- R5: The pattern 110 raises `hit` in the cycle after its final 0 is sampled.
- R6: Matches overlap. The input 01010 gives two `hit` pulses, two cycles apart.
- R7: `hit` is never high for two cycles in a row. From state 10, a 0 leads to 00 and a 1 leads to 01.
- R8: A 0 sampled while the state is 00 or 10 leads to state 00 with `hit` 0.
- R9: `hit` is 1 exactly when the state is 10. The state never takes the code 11, and that code, if it ever appeared, would go to 00 on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit, sampled each rising edge |
| hit | output | 1 | Match flag, decoded from the state |
| state_ab | output | 2 | Present state {A,B}: 00 start, 01 last bit 1, 10 match |

## Verification
The unused code 11 cannot be reached from the ports at all. The machine's only contact with it is the fall-back path, so that path is covered by a property stating that the code never appears, together with the `hit`/state relation. Among the cases that can be driven, the hardest is a reset that arrives in the middle of a half-received pattern while the clean-start history must still be honoured. Directed sequences place the reset right after a 1 and then send a 0. Overlapping trains such as 01010 and long runs of 1s ending in 0 are also driven directly. A fixed-seed random stream of several hundred bits, with occasional resets, is compared against a two-bit history model in the bench.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        SD_START = 2'b00,
        SD_ONE   = 2'b01,
        SD_MATCH = 2'b10,
        SD_SPARE = 2'b11
    } sd_state_e;

    typedef struct packed {
        logic a;
        logic b;
    } sd_ab_t;

    // Two-level next-state equations for the A and B flip-flops.
    function automatic sd_ab_t sd_next(input sd_ab_t cur, input logic bit_in);
        sd_ab_t nxt;
        nxt.a = ~cur.a & cur.b & ~bit_in;
        nxt.b = bit_in & ~(cur.a & cur.b);
        return nxt;
    endfunction

    // Moore decode: flag only in the match code.
    function automatic logic sd_flag(input sd_ab_t cur);
        return cur.a & ~cur.b;
    endfunction

endpackage

// File: rtl/seqdet_next.sv
module seqdet_next
    import seqdet_pkg::*;
(
    input  sd_ab_t cur_ab,
    input  logic   bit_in,
    output sd_ab_t nxt_ab
);
    always_comb begin
        nxt_ab = sd_next(cur_ab, bit_in);
    end
endmodule

// File: rtl/seqdet_reg.sv
module seqdet_reg
    import seqdet_pkg::*;
#(
    parameter sd_state_e RESET_CODE = SD_START
) (
    input  logic   clk,
    input  logic   rst,
    input  sd_ab_t d_ab,
    output sd_ab_t q_ab
);
    localparam sd_ab_t RESET_AB = sd_ab_t'(RESET_CODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_ab <= RESET_AB;
        end else begin
            q_ab <= d_ab;
        end
    end
endmodule

// File: rtl/seqdet_decode.sv
module seqdet_decode
    import seqdet_pkg::*;
(
    input  sd_ab_t cur_ab,
    output logic   flag
);
    always_comb begin
        flag = sd_flag(cur_ab);
    end
endmodule

// File: rtl/seqdet_top.sv
module seqdet_top
    import seqdet_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               din,
    output logic               hit,
    output logic [STATE_W-1:0] state_ab
);
    sd_ab_t cur_ab;
    sd_ab_t nxt_ab;

    seqdet_next u_next (
        .cur_ab (cur_ab),
        .bit_in (din),
        .nxt_ab (nxt_ab)
    );

    seqdet_reg #(
        .RESET_CODE (SD_START)
    ) u_reg (
        .clk  (clk),
        .rst  (rst),
        .d_ab (nxt_ab),
        .q_ab (cur_ab)
    );

    seqdet_decode u_dec (
        .cur_ab (cur_ab),
        .flag   (hit)
    );

    assign state_ab = {cur_ab.a, cur_ab.b};
endmodule

// File: rtl/seqdet_chk.sv
module seqdet_chk (
    input logic       clk,
    input logic       rst,
    input logic       din,
    input logic       hit,
    input logic [1:0] state_ab
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (state_ab == 2'b00 && !hit));

    // R2
    one_seen_chk: assert property (@(posedge clk) disable iff (rst)
        din |=> (state_ab == 2'b01 && !hit));

    // R3
    match_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (state_ab == 2'b01 && !din) |=> (hit && state_ab == 2'b10));

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit);

    // R8
    zero_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state_ab != 2'b01 && !din) |=> (state_ab == 2'b00 && !hit));

    // R9
    spare_code_chk: assert property (@(posedge clk) disable iff (rst)
        state_ab != 2'b11);

    // R9
    flag_state_chk: assert property (@(posedge clk) disable iff (rst)
        hit == (state_ab == 2'b10));
endmodule

bind seqdet_top seqdet_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .din      (din),
    .hit      (hit),
    .state_ab (state_ab)
);

// File: tb/tb_seqdet_top.sv
module tb_seqdet_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic       hit;
    logic [1:0] state_ab;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // bench history: h1 = newest sampled bit, h2 = the one before
    logic h1 = 1'b0;
    logic h2 = 1'b0;

    always #10 clk = ~clk;

    seqdet_top dut (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .hit      (hit),
        .state_ab (state_ab)
    );

    function automatic logic [1:0] exp_state(input logic n1, input logic n2);
        if (n1) return 2'b01;
        if (n2) return 2'b10;
        return 2'b00;
    endfunction

    task automatic check(input string req);
        logic [1:0] es;
        logic ez;
        es = exp_state(h1, h2);
        ez = (es == 2'b10);
        total++;
        if (state_ab !== es || hit !== ez) begin
            bad++;
            $display("FAIL %s: state=%b hit=%b expected state=%b hit=%b",
                     req, state_ab, hit, es, ez);
        end
    endtask

    task automatic check_hit(input logic ez, input string req);
        total++;
        if (hit !== ez) begin
            bad++;
            $display("FAIL %s: hit=%b expected %b", req, hit, ez);
        end
    endtask

    task automatic step(input logic b, input string req);
        din = b;
        @(posedge clk);
        h2 = h1;
        h1 = b;
        @(negedge clk);
        check(req);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        h1 = 1'b0;
        h2 = 1'b0;
        @(negedge clk);
        check("R1");
        rst = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();

        // R8: zeros keep the start code
        step(1'b0, "R8");
        step(1'b0, "R8");
        // R2 then R3
        step(1'b1, "R2");
        step(1'b0, "R3");
        // R7: match then 1
        step(1'b1, "R7");
        step(1'b0, "R3");
        // R7: match then 0 -> start
        step(1'b0, "R7");

        // R4: 0,1,0
        do_reset();
        step(1'b0, "R4");
        step(1'b1, "R4");
        step(1'b0, "R4");
        check_hit(1'b1, "R4");

        // R5: 1,1,0
        do_reset();
        step(1'b1, "R5");
        step(1'b1, "R5");
        step(1'b0, "R5");
        check_hit(1'b1, "R5");

        // R6: 0,1,0,1,0 gives two pulses
        do_reset();
        step(1'b0, "R6");
        step(1'b1, "R6");
        step(1'b0, "R6");
        check_hit(1'b1, "R6");
        step(1'b1, "R6");
        check_hit(1'b0, "R6");
        step(1'b0, "R6");
        check_hit(1'b1, "R6");

        // R1: reset clears a pending 1, following 0 gives no flag
        step(1'b1, "R2");
        do_reset();
        step(1'b0, "R1");
        check_hit(1'b0, "R1");

        // R2: long run of ones then a zero
        for (int i = 0; i < 6; i++) step(1'b1, "R2");
        step(1'b0, "R5");

        // random stream with occasional resets, R9 relation checked in check()
        for (int i = 0; i < 600; i++) begin
            if (($urandom % 50) == 0) begin
                do_reset();
            end else begin
                step(1'($urandom % 2), "R9");
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule